// File: doc/BRIEF.md
# Three-Phase Reset-Synchronous PWM Timer

The block is a 16-bit up-counter with one period register and three compare registers. It produces three complementary PWM pairs, six pins in all, that share one counter and so stay phase-locked. The counter counts from zero up to the period value and returns to zero on the next count. At that wrap each positive-phase output goes high. Each one goes low again when the counter reaches its own compare value. Each negative-phase pin is the inverse of its partner.

The counter advances on a count strobe. The strobe comes either from the system clock divided by 1, 4, 16 or 64, or from a synchronised external clock pin. For the external pin the counted edge is selectable. Software uses a single write port with a 3-bit address to control the block:

- a run bit,
- a mode field, which is locked while the timer runs,
- a 6-bit pin enable mask,
- an initial-level register that sets the positive outputs while stopped,
- a counter preset.

Top module: `pwm3_rsync_timer`

## Requirements
- R1: After reset every bit of pwm_o and pwm_oe_o is 0, the mode field is 00 and the counter is 0.
- R2: Register map (write only, addr): 0 control, 1 period, 2/3/4 compare of phases U/V/W, 5 pin enable mask (bits 5:0), 6 initial level (bits 2:0 for U/V/W), 7 counter preset. Control bits are: [0] run, [2:1] mode (01 = three-phase PWM), [5:3] clock select, [7:6] edge select. The counter goes 0..P (P = period) and clears on the tick after it equals P. A positive output therefore repeats every P+1 ticks.
- R3: A positive output is high while the counter is in 0..C (C = compare) and low for the rest of the cycle. C=0 gives a one-tick pulse, and C greater than or equal to P keeps it high the whole cycle.
- R4: pwm_o[2:0] are the positive phases U,V,W and pwm_o[5:3] the negative phases U,V,W. Each negative pin is the inverse of its positive partner whenever both are enabled.
- R5: Clock select 0,1,2,3 ticks once every 1, 4, 16, 64 clocks. Values 4 to 7 take ticks from ext_clk_i.
- R6: With the external clock, edge select 00 counts rising edges, 01 counts falling edges, and 1x counts both.
- R7: A control write made while run is 1 leaves the mode field unchanged. The other control fields are still written.
- R8: Writing run=1 starts counting from the counter value. Writing run=0 halts the counter, and it keeps its value until restarted.
- R9: In three-phase mode, pin i is driven and pwm_oe_o[i] is 1 only when mask bit i is 1. A masked pin reads 0.
- R10: While stopped, the positive outputs take the initial-level bits and the negative outputs their inverse. From reset with level 000 every positive output begins low.
- R11: With a mode other than 01, all pins are 0, pwm_oe_o is 0 and the counter does not advance even if run is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| pwm_o | output | 6 | PWM pins: [2:0] positive U,V,W, [5:3] negative U,V,W |
| pwm_oe_o | output | 6 | Per-pin drive enable |

## Verification
The hardest state to reach from the ports is a halt in the middle of a PWM cycle followed by a restart. A correct design resumes from the held count and does not restart the cycle. The bench starts from a preset of zero and stops the timer after a known number of ticks. It waits a long idle gap and then restarts. It then checks that the first wrap comes after exactly the remaining ticks. The edge-qualified external clock is driven by a background toggler with a fixed half period. This lets the rise-to-rise spacing of a phase output separate rising, falling and both-edge counting.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_CH  = 3;
  localparam int NUM_PIN = 2 * NUM_CH;
  localparam int ADDR_W  = 3;
  localparam int PRE_W   = 6;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP0   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_INIT   = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_PRESET = 3'd7;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_TRI = 2'b01;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic [2:0] clk_sel;
    logic [1:0] mode;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/pwm3_tick_gen.sv
module pwm3_tick_gen
  import pwm3_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] clk_sel_i,
  input  logic [1:0] edge_sel_i,
  input  logic       ext_clk_i,
  output logic       tick_o
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] div_mask;
  logic [2:0]    sync_q;
  logic          int_tick, ext_tick, ext_rise, ext_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[1:0], ext_clk_i};
    end
  end

  always_comb begin
    div_mask = '0;
    for (int b = 0; b < PW; b++)
      if (b < 2 * int'(clk_sel_i[1:0])) div_mask[b] = 1'b1;
  end

  assign int_tick = ((pre_q & div_mask) == div_mask);
  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign ext_fall = ~sync_q[1] & sync_q[2];

  always_comb begin
    if (edge_sel_i[1])      ext_tick = ext_rise | ext_fall;
    else if (edge_sel_i[0]) ext_tick = ext_fall;
    else                    ext_tick = ext_rise;
  end

  assign tick_o = clk_sel_i[2] ? ext_tick : int_tick;

  // R5
  undivided_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 3'd0) |-> tick_o);

  // R6
  ext_rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i[2] && edge_sel_i == 2'b00 && tick_o) |-> (sync_q[1] && !sync_q[2]));
endmodule

// File: rtl/pwm3_period_cnt.sv
module pwm3_period_cnt
  import pwm3_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (adv_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2
  clear_after_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && cnt_q == period_i) |=> (cnt_q == '0));

  // R8
  halt_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm3_phase_ch.sv
module pwm3_phase_ch
  import pwm3_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         adv_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         init_i,
  output logic         pos_o
);
  logic pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pos_q <= 1'b0;
    else if (!active_i)      pos_q <= init_i;
    else if (adv_i) begin
      if (wrap_i)            pos_q <= 1'b1;
      else if (cnt_i == cmp_i) pos_q <= 1'b0;
    end
  end

  assign pos_o = pos_q;

  // R3
  fall_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && adv_i && !wrap_i && cnt_i == cmp_i) |=> !pos_o);

  // R2
  rise_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && adv_i && wrap_i) |=> pos_o);
endmodule

// File: rtl/pwm3_rsync_timer.sv
module pwm3_rsync_timer
  import pwm3_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext_clk_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [CNT_W-1:0]    wr_data_i,
  output logic [NUM_PIN-1:0]  pwm_o,
  output logic [NUM_PIN-1:0]  pwm_oe_o
);
  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   period_q;
  logic [CNT_W-1:0]   cmp_q [NUM_CH];
  logic [NUM_PIN-1:0] mask_q;
  logic [NUM_CH-1:0]  init_q;
  logic [NUM_CH-1:0]  pos;
  logic [CNT_W-1:0]   cnt;
  logic               tick, wrap, active, adv, preset_wr, ctrl_wr;
  logic [NUM_PIN-1:0] raw_pins;
  logic               mode_on;

  assign ctrl_wr   = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign preset_wr = wr_en_i && (wr_addr_i == ADDR_PRESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '1;
      mask_q   <= '0;
      init_q   <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_CTRL: begin
          ctrl_q.run      <= wr_data_i[0];
          ctrl_q.clk_sel  <= wr_data_i[5:3];
          ctrl_q.edge_sel <= wr_data_i[7:6];
          if (!ctrl_q.run) ctrl_q.mode <= wr_data_i[2:1];
        end
        ADDR_PERIOD: period_q <= wr_data_i;
        ADDR_MASK:   mask_q   <= wr_data_i[NUM_PIN-1:0];
        ADDR_INIT:   init_q   <= wr_data_i[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_q[c] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_CMP0 + ADDR_W'(c)) cmp_q[c] <= wr_data_i;
    end
  end

  assign mode_on = (ctrl_q.mode == MODE_TRI);
  assign active  = ctrl_q.run && mode_on;
  assign adv     = active && tick;

  pwm3_tick_gen #(.PW(PRE_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_sel_i  (ctrl_q.clk_sel),
    .edge_sel_i (ctrl_q.edge_sel),
    .ext_clk_i  (ext_clk_i),
    .tick_o     (tick)
  );

  pwm3_period_cnt #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .load_i     (preset_wr),
    .load_val_i (wr_data_i),
    .period_i   (period_q),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm3_phase_ch #(.W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active),
      .adv_i    (adv),
      .wrap_i   (wrap),
      .cnt_i    (cnt),
      .cmp_i    (cmp_q[c]),
      .init_i   (init_q[c]),
      .pos_o    (pos[c])
    );
  end

  assign raw_pins = {~pos, pos};
  assign pwm_o    = mode_on ? (raw_pins & mask_q) : '0;
  assign pwm_oe_o = mode_on ? mask_q : '0;

  // R7
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && ctrl_q.run) |=> $stable(ctrl_q.mode));

  // R4
  complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pwm_oe_o) |-> (pwm_o[NUM_PIN-1:NUM_CH] == ~pwm_o[NUM_CH-1:0]));

  // R9
  masked_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_o & ~pwm_oe_o) == '0));

  // R11
  off_mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_on && !preset_wr) |=> $stable(cnt));
endmodule

// File: tb/pwm3_rsync_timer_tb_top.sv
module pwm3_rsync_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  pwm, oe;
  logic        ext_on = 1'b0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pwm3_rsync_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pwm_o(pwm), .pwm_oe_o(oe)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (ext_on) ext_clk = ~ext_clk;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(input bit run, input logic [1:0] mode,
                                       input logic [2:0] csel, input logic [1:0] esel);
    return {8'h00, esel, csel, mode, run};
  endfunction

  task automatic wait_rise(input int idx, output int n);
    logic prev;
    n = 0;
    prev = pwm[idx];
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      n++;
      if (!prev && pwm[idx]) return;
      prev = pwm[idx];
    end
    n = -1;
  endtask

  task automatic setup(input int p, input int cu, input int cv, input int cw,
                       input logic [2:0] csel, input logic [1:0] esel);
    wr(3'd0, ctrl(0, 2'b01, csel, esel));
    wr(3'd1, 16'(p));
    wr(3'd2, 16'(cu));
    wr(3'd3, 16'(cv));
    wr(3'd4, 16'(cw));
    wr(3'd5, 16'h003f);
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0000);
  endtask

  task automatic t_reset();
    check("R1 pins after reset", int'(pwm), 0);
    check("R1 oe after reset", int'(oe), 0);
  endtask

  task automatic t_start_stop();
    int n;
    setup(9, 3, 0, 12, 3'd0, 2'b00);
    check("R10 stopped level", int'(pwm), 6'b111000);
    wr(3'd0, ctrl(1, 2'b01, 3'd0, 2'b00));
    wait_rise(0, n);
    check("R8 first wrap from preset 0", n, 10);
    wr(3'd0, ctrl(0, 2'b01, 3'd0, 2'b00));
    wr(3'd7, 16'h0000);
    wr(3'd0, ctrl(1, 2'b01, 3'd0, 2'b00));
    repeat (3) @(negedge clk);
    wr(3'd0, ctrl(0, 2'b01, 3'd0, 2'b00));
    repeat (30) @(negedge clk);
    check("R10 level held while stopped", int'(pwm), 6'b111000);
    wr(3'd0, ctrl(1, 2'b01, 3'd0, 2'b00));
    wait_rise(0, n);
    check("R8 resume from held count", n, 5);
  endtask

  task automatic t_period_duty();
    int n, hu, hv, hw, inv_bad;
    wait_rise(0, n);
    check("R2 period P=9 div1", n, 10);
    hu = 0; hv = 0; hw = 0; inv_bad = 0;
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      hu += int'(pwm[0]); hv += int'(pwm[1]); hw += int'(pwm[2]);
      if (pwm[5:3] != ~pwm[2:0]) inv_bad++;
    end
    check("R3 duty C=3", hu, 4);
    check("R3 duty C=0 one tick", hv, 1);
    check("R3 duty C>P full high", hw, 10);
    check("R4 negative inverse", inv_bad, 0);
  endtask

  task automatic t_mode_lock();
    int n;
    wr(3'd0, ctrl(1, 2'b00, 3'd0, 2'b00));
    check("R7 oe unchanged after locked write", int'(oe), 6'h3f);
    wait_rise(0, n);
    wait_rise(0, n);
    check("R7 still running three-phase", n, 10);
  endtask

  task automatic t_prescale();
    int n;
    setup(9, 3, 0, 12, 3'd1, 2'b00);
    wr(3'd0, ctrl(1, 2'b01, 3'd1, 2'b00));
    wait_rise(0, n);
    wait_rise(0, n);
    check("R5 div4 period", n, 40);
    setup(1, 0, 0, 0, 3'd2, 2'b00);
    wr(3'd0, ctrl(1, 2'b01, 3'd2, 2'b00));
    wait_rise(0, n);
    wait_rise(0, n);
    check("R5 div16 period", n, 32);
  endtask

  task automatic t_external(input logic [1:0] esel, input int exp, input string req);
    int n;
    setup(3, 1, 0, 5, 3'd4, esel);
    wr(3'd0, ctrl(1, 2'b01, 3'd4, esel));
    wait_rise(0, n);
    wait_rise(0, n);
    check(req, n, exp);
  endtask

  task automatic t_mask_init();
    setup(9, 3, 0, 12, 3'd0, 2'b00);
    wr(3'd6, 16'h0005);
    @(negedge clk);
    check("R10 init level 101", int'(pwm), 6'b010101);
    wr(3'd5, 16'h0007);
    check("R9 masked oe", int'(oe), 6'h07);
    check("R9 masked pins low", int'(pwm), 6'b000101);
  endtask

  task automatic t_mode_off();
    wr(3'd0, ctrl(0, 2'b00, 3'd0, 2'b00));
    wr(3'd0, ctrl(1, 2'b00, 3'd0, 2'b00));
    repeat (20) @(negedge clk);
    check("R11 pins low off mode", int'(pwm), 0);
    check("R11 oe low off mode", int'(oe), 0);
  endtask

  task automatic t_off_holds();
    int n;
    wr(3'd0, ctrl(0, 2'b00, 3'd0, 2'b00));
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0004);
    wr(3'd0, ctrl(1, 2'b00, 3'd0, 2'b00));
    repeat (40) @(negedge clk);
    wr(3'd0, ctrl(0, 2'b00, 3'd0, 2'b00));
    wr(3'd0, ctrl(1, 2'b01, 3'd0, 2'b00));
    wait_rise(0, n);
    check("R11 counter frozen in off mode", n, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_stop();
    t_period_duty();
    t_mode_lock();
    t_prescale();
    ext_on = 1'b1;
    t_external(2'b00, 24, "R6 external rising");
    t_external(2'b01, 24, "R6 external falling");
    t_external(2'b10, 12, "R6 external both edges");
    ext_on = 1'b0;
    t_mask_init();
    t_mode_off();
    t_off_holds();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule